// File: doc/BRIEF.md
# Rotating Integer Register File

This block is the integer register file of a wide-issue core that supports software-pipelined loops. It holds 128 registers of 64 data bits, and each register also carries one tag bit. The tag marks a value produced by a speculative load that failed. The tag is written and read together with the data. Register 0 is fixed at zero. Registers 1 to 31 are always addressed directly. Registers 32 to 127 pass through a rotation base before they reach storage. Each rotate command makes every rotating value appear one logical register higher, and logical 127 wraps around to logical 32.

The file has two combinational read ports and one write port. Each port takes a 7-bit logical index. For a logical index L of 32 or more, the physical entry is 32 + ((L − 32 + base) mod 96). For L below 32 the physical entry is L. The base is a value from 0 to 95 held in a small update unit. That unit has three modes, each chosen in one cycle:
- `BASE_HOLD` keeps the base.
- `BASE_STEP` decrements the base, wrapping from 0 to 95. It is selected when the rotate strobe is high and clear is low.
- `BASE_ZERO` forces the base to 0. It is selected whenever clear is high.

A write always uses the base as it stood before the clock edge. A read always returns the stored contents as they stood before the edge, so there is no bypass from the write port.

Top module: `rot_gpr_file`

## Requirements
- R1: After reset every register reads data 0 with its tag clear, and the rotation base is 0, so each logical index maps to itself.
- R2: A write with `wr_en` high stores `wr_data` and `wr_tag`. From the next cycle on, any read of that logical index returns both, as long as no rotate or clear intervenes.
- R3: Logical register 0 always reads data 0 with tag 0. A write to index 0 has no effect on any register.
- R4: Logical registers 1 to 31 never change under a rotate or a base clear.
- R5: After one rotate, the value that was readable at logical L (32 ≤ L ≤ 126) is readable at L+1. The value that was at logical 127 is readable at logical 32.
- R6: After 96 consecutive rotates with no clear, every logical register reads the same value it read before the rotates.
- R7: A base clear restores the mapping in which each logical index equals its physical index. When clear and rotate are high in the same cycle, the clear wins.
- R8: A write issued in the same cycle as a rotate lands in the entry that the pre-rotate base selects. After the edge, that value is therefore readable one logical register higher.
- R9: A read of the index being written in the same cycle returns the old contents, not the new data.
- R10: The two read ports are independent. Each returns the register named by its own index in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; clears all entries and the base |
| rd_a_idx | input | 7 | Logical index, read port A |
| rd_a_data | output | 64 | Data, read port A |
| rd_a_tag | output | 1 | Deferred-exception tag, read port A |
| rd_b_idx | input | 7 | Logical index, read port B |
| rd_b_data | output | 64 | Data, read port B |
| rd_b_tag | output | 1 | Deferred-exception tag, read port B |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 7 | Logical index, write port |
| wr_data | input | 64 | Write data |
| wr_tag | input | 1 | Write tag |
| rot_step | input | 1 | Rotate command: advances the base by one step |
| base_clr | input | 1 | Synchronous clear of the rotation base |

## Verification
A wrong rotation base is not visible by itself. It shows up as a rotating logical register returning a neighbour's value on the very next read after the faulty edge. For that reason the bench reads two different indices on every cycle and compares both against a model of the logical view. A misplaced write shows up as a wrong value, or a stale tag, at the first later read of either the target register or the entry it overwrote. A bypass or a pre-rotated write base is caught in the same cycle or the cycle after, through the read-during-write and write-during-rotate cases.

// File: rtl/rrf_pkg.sv
package rrf_pkg;
    parameter int NREG    = 128;
    parameter int XLEN    = 64;
    parameter int NSTATIC = 32;

    localparam int IDX_W  = $clog2(NREG);
    localparam int NROT   = NREG - NSTATIC;
    localparam int BASE_W = $clog2(NROT);

    typedef struct packed {
        logic            tag;
        logic [XLEN-1:0] data;
    } rrf_entry_t;

    typedef enum logic [1:0] {
        BASE_HOLD = 2'd0,
        BASE_STEP = 2'd1,
        BASE_ZERO = 2'd2
    } base_op_e;
endpackage

// File: rtl/rrf_base.sv
module rrf_base
    import rrf_pkg::*;
#(
    parameter int ROT_N = NROT,
    parameter int BW    = BASE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rot_step,
    input  logic          base_clr,
    output logic [BW-1:0] rrb
);
    localparam logic [BW-1:0] TOP_VAL = BW'(ROT_N - 1);

    base_op_e      op;
    logic [BW-1:0] base_q;
    logic [BW-1:0] base_d;

    // pick the update mode; clear outranks rotate
    always_comb begin
        if (base_clr)      op = BASE_ZERO;
        else if (rot_step) op = BASE_STEP;
        else               op = BASE_HOLD;
    end

    always_comb begin
        base_d = base_q;
        unique case (op)
            BASE_HOLD: base_d = base_q;
            BASE_STEP: base_d = (base_q == '0) ? TOP_VAL : base_q - 1'b1;
            BASE_ZERO: base_d = '0;
            default:   base_d = base_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) base_q <= '0;
        else        base_q <= base_d;
    end

    assign rrb = base_q;

    a_r5_base_bound: assert property (@(posedge clk) disable iff (!rst_n)
        rrb <= TOP_VAL);
    a_r7_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        base_clr |=> rrb == '0);
    a_r5_step_down: assert property (@(posedge clk) disable iff (!rst_n)
        (rot_step && !base_clr && rrb != '0) |=> rrb == $past(rrb) - 1'b1);
    a_r6_base_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (rot_step && !base_clr && rrb == '0) |=> rrb == TOP_VAL);
endmodule

// File: rtl/rrf_remap.sv
module rrf_remap
    import rrf_pkg::*;
#(
    parameter int N_REG = NREG,
    parameter int N_FIX = NSTATIC,
    parameter int IW    = IDX_W,
    parameter int BW    = BASE_W
) (
    input  logic [IW-1:0] lidx,
    input  logic [BW-1:0] rrb,
    output logic [IW-1:0] pidx
);
    localparam int N_ROT = N_REG - N_FIX;

    logic [IW:0] offs;
    logic [IW:0] sum;

    always_comb begin
        offs = {1'b0, lidx} - (IW+1)'(N_FIX);
        sum  = offs + (IW+1)'(rrb);
        if (sum >= (IW+1)'(N_ROT))
            sum = sum - (IW+1)'(N_ROT);
        if (lidx < IW'(N_FIX))
            pidx = lidx;
        else
            pidx = IW'(sum + (IW+1)'(N_FIX));
    end
endmodule

// File: rtl/rrf_store.sv
module rrf_store
    import rrf_pkg::*;
#(
    parameter int N_REG = NREG,
    parameter int IW    = IDX_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [IW-1:0] widx,
    input  rrf_entry_t    wentry,
    input  logic [IW-1:0] raddr_a,
    input  logic [IW-1:0] raddr_b,
    output rrf_entry_t    rentry_a,
    output rrf_entry_t    rentry_b
);
    rrf_entry_t mem [N_REG];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N_REG; i++) mem[i] <= '0;
        end else if (we && widx != '0) begin
            mem[widx] <= wentry;
        end
    end

    assign rentry_a = mem[raddr_a];
    assign rentry_b = mem[raddr_b];

    a_r3_entry0_clear: assert property (@(posedge clk) disable iff (!rst_n)
        mem[0] == '0);
    a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (we && widx != '0) |=> mem[$past(widx)] == $past(wentry));
endmodule

// File: rtl/rot_gpr_file.sv
module rot_gpr_file
    import rrf_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [6:0]  rd_a_idx,
    output logic [63:0] rd_a_data,
    output logic        rd_a_tag,
    input  logic [6:0]  rd_b_idx,
    output logic [63:0] rd_b_data,
    output logic        rd_b_tag,
    input  logic        wr_en,
    input  logic [6:0]  wr_idx,
    input  logic [63:0] wr_data,
    input  logic        wr_tag,
    input  logic        rot_step,
    input  logic        base_clr
);
    localparam int NPORT = 3;   // 0: write, 1: read A, 2: read B

    logic [BASE_W-1:0] rrb;
    logic [IDX_W-1:0]  lidx [NPORT];
    logic [IDX_W-1:0]  pidx [NPORT];
    rrf_entry_t        went, rent_a, rent_b;

    assign lidx[0] = wr_idx;
    assign lidx[1] = rd_a_idx;
    assign lidx[2] = rd_b_idx;

    rrf_base #(.ROT_N(NROT), .BW(BASE_W)) u_base (
        .clk      (clk),
        .rst_n    (rst_n),
        .rot_step (rot_step),
        .base_clr (base_clr),
        .rrb      (rrb)
    );

    for (genvar p = 0; p < NPORT; p++) begin : g_map
        rrf_remap #(.N_REG(NREG), .N_FIX(NSTATIC), .IW(IDX_W), .BW(BASE_W)) u_map (
            .lidx (lidx[p]),
            .rrb  (rrb),
            .pidx (pidx[p])
        );
    end

    assign went.tag  = wr_tag;
    assign went.data = wr_data;

    rrf_store #(.N_REG(NREG), .IW(IDX_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (wr_en),
        .widx     (pidx[0]),
        .wentry   (went),
        .raddr_a  (pidx[1]),
        .raddr_b  (pidx[2]),
        .rentry_a (rent_a),
        .rentry_b (rent_b)
    );

    assign rd_a_data = rent_a.data;
    assign rd_a_tag  = rent_a.tag;
    assign rd_b_data = rent_b.data;
    assign rd_b_tag  = rent_b.tag;

    a_r3_zero_port_a: assert property (@(posedge clk) disable iff (!rst_n)
        rd_a_idx == '0 |-> (rd_a_data == '0 && !rd_a_tag));
    a_r4_static_map: assert property (@(posedge clk) disable iff (!rst_n)
        rd_b_idx < 7'(NSTATIC) |-> pidx[2] == rd_b_idx);
    a_r5_rot_region: assert property (@(posedge clk) disable iff (!rst_n)
        rd_a_idx >= 7'(NSTATIC) |-> pidx[1] >= 7'(NSTATIC));
endmodule

// File: tb/sim_rot_gpr_file.sv
`timescale 1ns/1ps
module sim_rot_gpr_file;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [6:0]  rd_a_idx, rd_b_idx, wr_idx;
    logic [63:0] rd_a_data, rd_b_data, wr_data;
    logic        rd_a_tag, rd_b_tag, wr_en, wr_tag, rot_step, base_clr;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    logic [63:0] m_data [128];
    logic        m_tag  [128];
    int          m_k;

    always #2.5 clk = ~clk;

    rot_gpr_file u0 (
        .clk(clk), .rst_n(rst_n),
        .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data), .rd_a_tag(rd_a_tag),
        .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data), .rd_b_tag(rd_b_tag),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .wr_tag(wr_tag),
        .rot_step(rot_step), .base_clr(base_clr)
    );

    task automatic model_reset();
        for (int i = 0; i < 128; i++) begin m_data[i] = '0; m_tag[i] = 1'b0; end
        m_k = 0;
    endtask

    task automatic check_port(string req, string port, int idx,
                              logic [63:0] ad, logic at);
        logic [63:0] ed;
        logic        et;
        ed = (idx == 0) ? 64'd0 : m_data[idx];
        et = (idx == 0) ? 1'b0  : m_tag[idx];
        total++;
        if (ad !== ed || at !== et) begin
            bad++;
            $display("FAIL %s port %s idx=%0d actual=%h/%b expected=%h/%b",
                     req, port, idx, ad, at, ed, et);
        end
    endtask

    // one clock cycle: drive, compare, then advance model at the edge
    task automatic cyc(string req, bit we, int wi, logic [63:0] wd, bit wt,
                       bit rot, bit clr, int ra, int rb);
        logic [63:0] td [128];
        logic        tt [128];
        wr_en = we; wr_idx = 7'(wi); wr_data = wd; wr_tag = wt;
        rot_step = rot; base_clr = clr;
        rd_a_idx = 7'(ra); rd_b_idx = 7'(rb);
        #1;
        check_port(req, "A", ra, rd_a_data, rd_a_tag);
        check_port(req, "B", rb, rd_b_data, rd_b_tag);
        @(posedge clk);
        if (we && wi != 0) begin m_data[wi] = wd; m_tag[wi] = wt; end
        for (int i = 0; i < 128; i++) begin td[i] = m_data[i]; tt[i] = m_tag[i]; end
        if (clr) begin
            for (int l = 32; l < 128; l++) begin
                m_data[l] = td[32 + ((l - 32 + m_k) % 96)];
                m_tag[l]  = tt[32 + ((l - 32 + m_k) % 96)];
            end
            m_k = 0;
        end else if (rot) begin
            for (int l = 32; l < 128; l++) begin
                m_data[32 + ((l - 32 + 1) % 96)] = td[l];
                m_tag[32 + ((l - 32 + 1) % 96)]  = tt[l];
            end
            m_k = (m_k + 1) % 96;
        end
        @(negedge clk);
    endtask

    task automatic read_all(string req);
        for (int i = 0; i < 128; i += 2) cyc(req, 0, 0, 0, 0, 0, 0, i, i + 1);
    endtask

    function automatic logic [63:0] rnd64();
        return {$urandom(), $urandom()};
    endfunction

    initial begin
        rst_n = 1'b0; wr_en = 0; wr_idx = 0; wr_data = 0; wr_tag = 0;
        rot_step = 0; base_clr = 0; rd_a_idx = 0; rd_b_idx = 0;
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: everything zero after reset
        read_all("R1");

        // R2: write/read with tags, R10 with split indices
        for (int i = 1; i < 128; i++)
            cyc("R2", 1, i, rnd64() ^ 64'(i), i[0], 0, 0, 128 - i, i / 2);
        read_all("R2");
        for (int i = 0; i < 20; i++)
            cyc("R10", 0, 0, 0, 0, 0, 0, $urandom_range(0, 127), $urandom_range(0, 127));

        // R3: writes to register 0 ignored
        cyc("R3", 1, 0, 64'hFFFF_FFFF_FFFF_FFFF, 1, 0, 0, 0, 5);
        cyc("R3", 0, 0, 0, 0, 0, 0, 0, 0);

        // R9: read during write of the same index sees old value
        cyc("R9", 1, 40, 64'hDEAD_BEEF_0000_0040, 1, 0, 0, 40, 40);
        cyc("R9", 1, 7, 64'h1234_0000_0000_0007, 0, 0, 0, 7, 40);
        cyc("R9", 0, 0, 0, 0, 0, 0, 7, 40);

        // R5/R4: single rotate and full readback, including 127 -> 32
        cyc("R5", 0, 0, 0, 0, 1, 0, 127, 32);
        read_all("R5");
        cyc("R4", 0, 0, 0, 0, 1, 0, 3, 31);
        cyc("R4", 0, 0, 0, 0, 0, 0, 3, 31);

        // R8: write concurrent with rotate uses old base
        cyc("R8", 1, 50, 64'hABCD_0000_0000_0050, 1, 1, 0, 50, 51);
        cyc("R8", 0, 0, 0, 0, 0, 0, 50, 51);
        cyc("R8", 1, 127, 64'hABCD_0000_0000_0127, 0, 1, 0, 127, 32);
        cyc("R8", 0, 0, 0, 0, 0, 0, 127, 32);

        // R6: 96 rotations bring the view back
        for (int i = 0; i < 96; i++)
            cyc("R6", 0, 0, 0, 0, 1, 0, 32 + i, 127 - i);
        read_all("R6");

        // R7: clear base, and clear beating rotate
        for (int i = 0; i < 5; i++) cyc("R7", 0, 0, 0, 0, 1, 0, 33, 90);
        cyc("R7", 0, 0, 0, 0, 0, 1, 33, 90);
        read_all("R7");
        cyc("R7", 0, 0, 0, 0, 1, 0, 60, 61);
        cyc("R7", 0, 0, 0, 0, 1, 1, 60, 61);
        read_all("R7");

        // mixed traffic
        for (int i = 0; i < 300; i++)
            cyc("R10", $urandom_range(0, 1), $urandom_range(0, 127), rnd64(),
                $urandom_range(0, 1), ($urandom_range(0, 3) == 0),
                ($urandom_range(0, 15) == 0),
                $urandom_range(0, 127), $urandom_range(0, 127));
        read_all("R5");

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog all-requirements actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule